// File: doc/BRIEF.md
# PCI Target I/O Window Decoder

This block watches the address phase of each PCI transaction and decides whether the device claims it as a target. It registers the 32-bit AD value and the four-bit command/byte-enable code on the first clock edge of a cycle. It then compares the address against two programmable I/O apertures.

The first aperture is a 4-byte window for an index/data register pair. It can be placed anywhere in the 32-bit I/O space. The second aperture is a 16-byte window for a per-function DMA register set, and it is only valid below address 0x10000.

On a claim, the block raises a hit strobe with a window identifier and a byte offset inside the window. It then drives DEVSEL# with medium decode timing. Everything it reports stays steady until the bus returns to idle.

A three-bit command register gates the decode: one enable for I/O space, one for memory space, and one for bus mastering. The register clears on reset and is loaded through a simple write strobe. Its contents are presented on an output so that neighbouring logic can use the memory and mastering enables. This decoder acts only on the I/O enable. Base registers live in the configuration block and arrive as plain inputs.

Top module: `pci_io_window_decoder`

## Requirements
- R1: During and right after reset, `hit` is 0, `devsel_n` is 1, `window_id` and `offset` are 0, and `cmd_en` is 3'b000.
- R2: A cycle with `cmd_wr`=1 loads `cmd_wdata` into `cmd_en`, visible after that edge. Bit 0 is the I/O enable, bit 1 is the memory enable and bit 2 is the bus-master enable. Bits 1 and 2 never cause a claim.
- R3: Only the I/O read code 4'b0010 and the I/O write code 4'b0011 on `cbe` can produce a hit. Every other code is never claimed: 0000, 0001, 0100, 0101, 0110, 0111, 1000, 1001, 1010, 1011, 1100, 1101, 1110 and 1111.
- R4: While `cmd_en[0]` is 0 at the address edge, no window hits, even when an address matches a base.
- R5: An I/O address whose bits [31:2] equal `legacy_base[31:2]` hits with `window_id`=0 and `offset`=address[1:0], at any location in the 32-bit space.
- R6: An I/O address whose bits [31:4] equal `dma_base[31:4]` hits with `window_id`=1 and `offset`=address[3:0].
- R7: When `dma_base[31:16]` is not zero, the DMA window never hits.
- R8: When an address falls in both windows, the legacy window wins (`window_id`=0).
- R9: The edge that samples `frame_n`=0 from idle captures the address, and `hit`/`window_id`/`offset` are valid right after it. `devsel_n` goes low one edge later (medium timing), and only for a hit.
- R10: The outputs hold through the cycle whatever AD and C/BE do. They clear (hit 0, id 0, offset 0, `devsel_n` 1) after the first edge in a busy cycle that samples `frame_n`=1 and `irdy_n`=1. Without a hit, id and offset read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Cycle framing, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad | input | 32 | Multiplexed address/data bus |
| cbe | input | 4 | Command (address phase) / byte enables |
| cmd_wr | input | 1 | Load strobe for the command register |
| cmd_wdata | input | 3 | New command register value |
| legacy_base | input | 32 | Base of the 4-byte index/data window |
| dma_base | input | 32 | Base of the 16-byte DMA window |
| cmd_en | output | 3 | Command register contents {master, memory, I/O} |
| hit | output | 1 | Cycle claimed by an I/O window |
| window_id | output | 1 | 0 = index/data window, 1 = DMA window |
| offset | output | 4 | Byte offset inside the claimed window |
| devsel_n | output | 1 | Device select, active low, medium timing |

## Verification
The bench sweeps all sixteen command codes against a matching address. A decoder that claimed a reserved, special or dual-address code, or a memory read, would raise `hit` where none is expected.

It places the two windows so that they overlap, to catch a wrong priority choice. It sets upper bits on the DMA base, which a decoder that compared only the aligned address would wrongly accept.

It changes AD during data phases and stretches cycles to expose outputs that follow the bus after the address phase. It counts edges from FRAME so that DEVSEL# one clock early or late shows up as a mismatch against the behavioural model.

// File: rtl/pcid_pkg.sv
`timescale 1ns/1ps
package pcid_pkg;

  typedef enum logic [3:0] {
    CMD_INT_ACK    = 4'h0,
    CMD_SPECIAL    = 4'h1,
    CMD_IO_READ    = 4'h2,
    CMD_IO_WRITE   = 4'h3,
    CMD_RSVD_4     = 4'h4,
    CMD_RSVD_5     = 4'h5,
    CMD_MEM_READ   = 4'h6,
    CMD_MEM_WRITE  = 4'h7,
    CMD_RSVD_8     = 4'h8,
    CMD_RSVD_9     = 4'h9,
    CMD_CFG_READ   = 4'hA,
    CMD_CFG_WRITE  = 4'hB,
    CMD_MEM_RD_MUL = 4'hC,
    CMD_DUAL_ADDR  = 4'hD,
    CMD_MEM_RD_LN  = 4'hE,
    CMD_MEM_WR_INV = 4'hF
  } bus_cmd_e;

  typedef enum logic {
    WIN_INDEX = 1'b0,
    WIN_DMA   = 1'b1
  } win_id_e;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_BUSY = 1'b1
  } bus_phase_e;

  localparam int EN_IO  = 0;
  localparam int EN_MEM = 1;
  localparam int EN_BM  = 2;

  function automatic logic is_io_access(input logic [3:0] code);
    return (code == CMD_IO_READ) || (code == CMD_IO_WRITE);
  endfunction

endpackage

// File: rtl/pcid_cmd_reg.sv
`timescale 1ns/1ps
module pcid_cmd_reg #(
  parameter int EN_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [EN_W-1:0] wdata,
  output logic [EN_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wr) begin
      q <= wdata;
    end
  end

endmodule

// File: rtl/pcid_cycle_track.sv
`timescale 1ns/1ps
module pcid_cycle_track
  import pcid_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic frame_n,
  input  logic irdy_n,
  output logic start,
  output logic finish,
  output logic busy
);

  bus_phase_e phase_q;

  assign start  = (phase_q == PH_IDLE) && !frame_n;
  assign finish = (phase_q == PH_BUSY) && frame_n && irdy_n;
  assign busy   = (phase_q == PH_BUSY);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
    end else if (start) begin
      phase_q <= PH_BUSY;
    end else if (finish) begin
      phase_q <= PH_IDLE;
    end
  end

endmodule

// File: rtl/pcid_window_match.sv
`timescale 1ns/1ps
module pcid_window_match #(
  parameter int AW         = 32,
  parameter int SPAN_BITS  = 2,
  parameter int LIMIT_BITS = 32
) (
  input  logic [AW-1:0]        addr,
  input  logic [AW-1:0]        base,
  output logic                 match,
  output logic [SPAN_BITS-1:0] offs
);

  logic base_ok;
  logic unused_base_low;

  assign unused_base_low = ^base[SPAN_BITS-1:0];

  generate
    if (LIMIT_BITS < AW) begin : g_limited
      assign base_ok = ~|base[AW-1:LIMIT_BITS];
    end else begin : g_anywhere
      assign base_ok = 1'b1;
    end
  endgenerate

  assign match = base_ok && (addr[AW-1:SPAN_BITS] == base[AW-1:SPAN_BITS]);
  assign offs  = addr[SPAN_BITS-1:0];

endmodule

// File: rtl/pci_io_window_decoder.sv
`timescale 1ns/1ps
module pci_io_window_decoder
  import pcid_pkg::*;
#(
  parameter int AW        = 32,
  parameter int EN_W      = 3,
  parameter int IDX_BITS  = 2,
  parameter int DMA_BITS  = 4,
  parameter int DMA_LIMIT = 16,
  localparam int OFF_W    = (IDX_BITS > DMA_BITS) ? IDX_BITS : DMA_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic [AW-1:0]    ad,
  input  logic [3:0]       cbe,
  input  logic             cmd_wr,
  input  logic [EN_W-1:0]  cmd_wdata,
  input  logic [AW-1:0]    legacy_base,
  input  logic [AW-1:0]    dma_base,
  output logic [EN_W-1:0]  cmd_en,
  output logic             hit,
  output logic             window_id,
  output logic [OFF_W-1:0] offset,
  output logic             devsel_n
);

  logic                cyc_start, cyc_finish, cyc_busy;
  logic                idx_match, dma_match;
  logic [IDX_BITS-1:0] idx_offs;
  logic [DMA_BITS-1:0] dma_offs;
  logic                io_ok, idx_hit, dma_hit;
  logic                hit_q, id_q, dev_q;
  logic [OFF_W-1:0]    off_q, off_sel;

  pcid_cmd_reg #(.EN_W(EN_W)) u_cmd (
    .clk(clk), .rst(rst), .wr(cmd_wr), .wdata(cmd_wdata), .q(cmd_en)
  );

  pcid_cycle_track u_track (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n),
    .start(cyc_start), .finish(cyc_finish), .busy(cyc_busy)
  );

  pcid_window_match #(.AW(AW), .SPAN_BITS(IDX_BITS), .LIMIT_BITS(AW)) u_idx (
    .addr(ad), .base(legacy_base), .match(idx_match), .offs(idx_offs)
  );

  pcid_window_match #(.AW(AW), .SPAN_BITS(DMA_BITS), .LIMIT_BITS(DMA_LIMIT)) u_dma (
    .addr(ad), .base(dma_base), .match(dma_match), .offs(dma_offs)
  );

  assign io_ok   = cmd_en[EN_IO] && is_io_access(cbe);
  assign idx_hit = io_ok && idx_match;
  assign dma_hit = io_ok && dma_match && !idx_match;

  always_comb begin
    off_sel = '0;
    if (idx_hit) begin
      off_sel = OFF_W'(idx_offs);
    end else if (dma_hit) begin
      off_sel = OFF_W'(dma_offs);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
      id_q  <= WIN_INDEX;
      off_q <= '0;
      dev_q <= 1'b0;
    end else if (cyc_start) begin
      hit_q <= idx_hit || dma_hit;
      id_q  <= dma_hit ? WIN_DMA : WIN_INDEX;
      off_q <= off_sel;
      dev_q <= 1'b0;
    end else if (cyc_finish) begin
      hit_q <= 1'b0;
      id_q  <= WIN_INDEX;
      off_q <= '0;
      dev_q <= 1'b0;
    end else if (cyc_busy) begin
      dev_q <= hit_q;
    end
  end

  assign hit       = hit_q;
  assign window_id = id_q;
  assign offset    = off_q;
  assign devsel_n  = !dev_q;

endmodule

// File: rtl/pci_io_window_decoder_chk.sv
`timescale 1ns/1ps
module pci_io_window_decoder_chk #(
  parameter int AW    = 32,
  parameter int EN_W  = 3,
  parameter int OFF_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       cbe,
  input logic [AW-1:0]    dma_base,
  input logic [EN_W-1:0]  cmd_en,
  input logic             hit,
  input logic             window_id,
  input logic [OFF_W-1:0] offset,
  input logic             devsel_n
);

  // R1: outputs quiet after a reset edge
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!hit && devsel_n && cmd_en == '0));

  // R3 and R4: a new claim needs an I/O code and the I/O enable at the address edge
  a_r3_io_code_only: assert property (@(posedge clk) disable iff (rst)
    $rose(hit) |-> ($past(cbe) == 4'h2 || $past(cbe) == 4'h3));

  a_r4_io_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(hit) |-> $past(cmd_en[0]));

  // R7: a DMA claim needs a base below the 64K limit
  a_r7_dma_limit: assert property (@(posedge clk) disable iff (rst)
    ($rose(hit) && window_id) |-> ($past(dma_base[AW-1:16]) == '0));

  // R9: DEVSEL# only with a claim, and never in the capture cycle itself
  a_r9_devsel_needs_hit: assert property (@(posedge clk) disable iff (rst)
    !devsel_n |-> hit);

  a_r9_medium_timing: assert property (@(posedge clk) disable iff (rst)
    $fell(devsel_n) |-> $past(hit));

  // R10: claim details hold while the claim lasts
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (hit && $past(hit)) |-> ($stable(window_id) && $stable(offset)));

endmodule

bind pci_io_window_decoder pci_io_window_decoder_chk #(
  .AW(AW), .EN_W(EN_W), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst(rst), .cbe(cbe), .dma_base(dma_base), .cmd_en(cmd_en),
  .hit(hit), .window_id(window_id), .offset(offset), .devsel_n(devsel_n)
);

// File: tb/pci_io_window_decoder_test.sv
`timescale 1ns/1ps
module pci_io_window_decoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic        cmd_wr = 1'b0;
  logic [2:0]  cmd_wdata = '0;
  logic [31:0] legacy_base = '0;
  logic [31:0] dma_base = '0;
  logic [2:0]  cmd_en;
  logic        hit, window_id, devsel_n;
  logic [3:0]  offset;

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  pci_io_window_decoder uut (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .ad(ad), .cbe(cbe),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .legacy_base(legacy_base),
    .dma_base(dma_base), .cmd_en(cmd_en), .hit(hit), .window_id(window_id),
    .offset(offset), .devsel_n(devsel_n)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  bit       m_busy, m_hit, m_id, m_dev;
  int       m_off;
  bit [2:0] m_cmd;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_hit = 0; m_id = 0; m_dev = 0; m_off = 0; m_cmd = 0;
    end else begin
      bit [2:0] prev_cmd;
      prev_cmd = m_cmd;
      if (cmd_wr) m_cmd = cmd_wdata;
      if (!m_busy) begin
        if (!frame_n) begin
          bit io_cyc, in_idx, in_dma;
          longint a;
          a = ad;
          io_cyc = (cbe == 4'd2 || cbe == 4'd3) && prev_cmd[0];
          in_idx = io_cyc && (a / 4 == longint'(legacy_base) / 4);
          in_dma = io_cyc && (longint'(dma_base) < 65536) && (a / 16 == longint'(dma_base) / 16);
          m_busy = 1;
          m_dev = 0;
          m_hit = in_idx || in_dma;
          m_id  = !in_idx && in_dma;
          m_off = in_idx ? int'(a % 4) : (in_dma ? int'(a % 16) : 0);
        end
      end else if (frame_n && irdy_n) begin
        m_busy = 0; m_hit = 0; m_id = 0; m_dev = 0; m_off = 0;
      end else begin
        m_dev = m_hit;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(hit == m_hit && window_id == m_id && offset == m_off[3:0] && devsel_n == !m_dev,
            cur_req, {hit, window_id, offset, devsel_n},
            {m_hit, m_id, m_off[3:0], !m_dev});
    end
  end

  task automatic write_cmd(input logic [2:0] v);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_wdata = v;
    @(negedge clk);
    cmd_wr = 1'b0;
    check(cmd_en == v, "R2", cmd_en, v);
  endtask

  // one cycle: address phase, data phases (AD scrambled), then idle
  task automatic bus_cycle(input logic [3:0] c, input logic [31:0] a, input int extra,
                           input bit e_hit, input bit e_id, input logic [3:0] e_off,
                           input string req);
    cur_req = req;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad = a; cbe = c;
    @(negedge clk);
    check(hit == e_hit, {req, " hit"}, hit, e_hit);
    check(window_id == e_id && offset == e_off, {req, " id/offset"},
          {window_id, offset}, {e_id, e_off});
    check(devsel_n == 1'b1, "R9 devsel early", devsel_n, 1);
    frame_n = 1'b1; irdy_n = 1'b0; ad = ~a; cbe = 4'hF;
    @(negedge clk);
    check(devsel_n == !e_hit, "R9 devsel medium", devsel_n, !e_hit);
    for (int i = 0; i < extra; i++) begin
      ad = ad + 32'h1111_0001; cbe = 4'h2;
      @(negedge clk);
      check(hit == e_hit && offset == e_off && window_id == e_id, "R10 hold",
            {hit, window_id, offset}, {e_hit, e_id, e_off});
    end
    irdy_n = 1'b1;
    @(negedge clk);
    check(!hit && devsel_n && offset == 0 && !window_id, "R10 clear",
          {hit, window_id, offset, devsel_n}, 7'b0000001);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!hit && devsel_n && cmd_en == 0 && offset == 0, "R1",
          {hit, devsel_n, cmd_en, offset}, 8'b01000000);
    rst = 1'b0;
    legacy_base = 32'h0000_03E0;
    dma_base    = 32'h0000_1230;

    cur_req = "R4";
    bus_cycle(4'h2, 32'h0000_03E1, 0, 0, 0, 4'h0, "R4 io disabled");

    write_cmd(3'b001);
    bus_cycle(4'h2, 32'h0000_03E1, 0, 1, 0, 4'h1, "R5 idx read");
    bus_cycle(4'h3, 32'h0000_03E3, 1, 1, 0, 4'h3, "R5 idx write");
    bus_cycle(4'h2, 32'h0000_03E4, 0, 0, 0, 4'h0, "R5 idx miss");
    bus_cycle(4'h3, 32'h0000_123A, 0, 1, 1, 4'hA, "R6 dma");
    bus_cycle(4'h2, 32'h0000_1240, 0, 0, 0, 4'h0, "R6 dma miss");

    for (int k = 0; k < 16; k++) begin
      bit claim;
      claim = (k == 2 || k == 3);
      bus_cycle(4'(k), 32'h0000_03E2, 0, claim, 0, claim ? 4'h2 : 4'h0, "R3 code sweep");
    end

    write_cmd(3'b110);
    check(cmd_en[2] == 1'b1, "R2 master bit", cmd_en[2], 1);
    bus_cycle(4'h2, 32'h0000_03E1, 0, 0, 0, 4'h0, "R4 io off");
    bus_cycle(4'h6, 32'h0000_03E1, 0, 0, 0, 4'h0, "R3 mem read");

    write_cmd(3'b001);
    dma_base = 32'h0001_1230;
    bus_cycle(4'h2, 32'h0001_1234, 0, 0, 0, 4'h0, "R7 high dma base");
    bus_cycle(4'h2, 32'h0000_1234, 0, 0, 0, 4'h0, "R7 low alias");

    legacy_base = 32'h0000_1234;
    dma_base    = 32'h0000_1230;
    bus_cycle(4'h2, 32'h0000_1235, 0, 1, 0, 4'h1, "R8 overlap idx");
    bus_cycle(4'h2, 32'h0000_1238, 0, 1, 1, 4'h8, "R8 dma part");

    legacy_base = 32'hFFFF_FFFC;
    bus_cycle(4'h3, 32'hFFFF_FFFF, 3, 1, 0, 4'h3, "R5 top of space");
    bus_cycle(4'h2, 32'h0000_123C, 4, 1, 1, 4'hC, "R10 long cycle");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule